// File: doc/BRIEF.md
# Card Detect Control and Wake Logic

This block sits on the socket side of a removable card slot. It samples the two active-low card-detect pins, reports the live level of the two voltage-sense pins, and turns detect-pin activity into a sticky card-change flag, a gated status-change interrupt, an active-low wake request, and an optional one-cycle reset pulse. That pulse goes to the socket's other registers when the card is pulled out. Software can also raise the card-change event itself through a self-clearing trigger bit.

Four byte-wide registers are reached through a simple single-port bus. A write is taken on the clock edge where `wr_en` is high. Read data is combinational from `reg_sel`. The selector codes are fixed: 0 is the detect/general control register, 1 is the interrupt-configuration register, 2 is the status-change register and 3 is the global-control register. Two reset inputs exist. The global reset clears everything. A bus reset spares the wake-related state when power-management-event mode is on.

Top module: `cdet_ctl_top`

## Requirements
- R1: After either reset with `pme_en` low, every stored bit is 0, `wake_n` is 1, and `csc_irq` and `regs_rst_pulse` are 0.
- R2: Control register (sel 0) read: bit 7 is the live `vsense[1]` and bit 6 is the live `vsense[0]`. Bit 4 (resume enable) and bit 1 (reset-on-removal) read back the last written value. Bits 5, 3, 2 and 0 always read 0, and writes to them store nothing.
- R3: A write to sel 0 with bit 5 set, while the card-detect enable is 1, sets the card-change flag after the edge that follows the write's edge. If the enable is 0, the same write leaves the flag unchanged.
- R4: Each detect pin is registered and compared with its previous sample. A change on either pin sets the card-change flag, visible after the second clock edge that samples the new pin level.
- R5: The card-change flag reads as bit 3 of sel 2. It stays set until software writes 1 to that bit. A set condition in the same cycle as the clearing write wins.
- R6: `csc_irq` is high exactly when the card-change flag and the card-detect enable (bit 3 of sel 1) are both 1.
- R7: With resume enable set, a detect-pin change drives `wake_n` low in the same cycle the flag sets. It stays low until the flag is actually cleared. With resume enable clear, or for a software trigger, `wake_n` stays high.
- R8: A card counts as present when all detect pins are low. A change from present to not present, with bit 1 of sel 0 set, gives exactly one cycle of `regs_rst_pulse`, in the same cycle the flag sets. Insertion gives no pulse.
- R9: When global-control bit 2 (sel 3) is 1, a clearing write to the flag in the cycle right after a software trigger write cancels that trigger, so the flag ends 0. When bit 2 is 0, the trigger survives and the flag ends 1.
- R10: A bus reset with `pme_en` high keeps the resume enable, the flag and the wake state, and clears the other stored bits. With `pme_en` low, a bus reset clears everything, as the global reset always does.
- R11: Reading sel 1 returns only the enable in bit 3, and reading sel 3 returns only the option in bit 2. All other bits of those registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| glb_rst | input | 1 | Global synchronous reset, clears all state |
| bus_rst | input | 1 | Bus synchronous reset, spares wake state when `pme_en` is 1 |
| pme_en | input | 1 | Power-management-event mode |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 interrupt config, 2 status, 3 global |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `reg_sel` |
| cd_n | input | NUM_CD | Active-low card-detect pins, already debounced |
| vsense | input | 2 | Voltage-sense pins |
| csc_irq | output | 1 | Card status-change interrupt |
| wake_n | output | 1 | Active-low wake (ring-indicate) request |
| regs_rst_pulse | output | 1 | One-cycle reset to the socket's other registers on removal |

## Verification
A wrong previous-sample register would show up as a missed or doubled card-change flag, and as a stray `wake_n` fall or reset pulse. These appear at the ports two edges after a pin moves. A stuck software-trigger latch shows on the next status read as a flag that keeps coming back after it is cleared, or as one that never arrives. A wrong reset domain only shows after a bus reset with `pme_en` high, where the status and control reads come back with the wrong bits. For this reason the bench reads every register after each directed reset and compares all four outputs on every cycle of random traffic.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

    localparam int DW = 8;

    // register selector codes seen on reg_sel
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_INTCFG = 2'd1,
        SEL_STAT   = 2'd2,
        SEL_GCTL   = 2'd3
    } reg_sel_e;

    // bit positions inside the registers
    localparam int POS_VS_HI   = 7;
    localparam int POS_VS_LO   = 6;
    localparam int POS_SWTRIG  = 5;
    localparam int POS_RESUME  = 4;
    localparam int POS_RMRST   = 1;
    localparam int POS_CDEN    = 3;
    localparam int POS_CDCHG   = 3;
    localparam int POS_SWCLR   = 2;

    typedef struct packed {
        logic resume_en;
        logic rm_rst_en;
        logic cd_en;
        logic swclr_opt;
    } cfg_t;

    typedef struct packed {
        logic change;
        logic removal;
    } cd_evt_t;

    typedef struct packed {
        logic          wr;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } bus_wr_t;

    function automatic logic [DW-1:0] place_bit(input int pos, input logic v);
        logic [DW-1:0] r;
        r      = '0;
        r[pos] = v;
        return r;
    endfunction

    function automatic logic hits(input bus_wr_t w, input reg_sel_e s, input int pos);
        return w.wr && (w.sel == s) && w.data[pos];
    endfunction

endpackage

// File: rtl/cdet_sampler.sv
module cdet_sampler
    import cdet_pkg::*;
#(
    parameter int NUM_CD = 2
) (
    input  logic              clk,
    input  logic              any_rst,
    input  logic [NUM_CD-1:0] cd_n,
    output cd_evt_t           evt
);

    logic [NUM_CD-1:0] cur_q;
    logic [NUM_CD-1:0] prev_q;

    for (genvar i = 0; i < NUM_CD; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (any_rst) begin
                cur_q[i]  <= cd_n[i];
                prev_q[i] <= cd_n[i];
            end else begin
                cur_q[i]  <= cd_n[i];
                prev_q[i] <= cur_q[i];
            end
        end
    end

    logic present_now;
    logic present_before;

    always_comb begin
        present_now    = ~|cur_q;
        present_before = ~|prev_q;
        evt.change     = |(cur_q ^ prev_q);
        evt.removal    = present_before & ~present_now;
    end

endmodule

// File: rtl/cdet_regs.sv
module cdet_regs
    import cdet_pkg::*;
(
    input  logic    clk,
    input  logic    glb_rst,
    input  logic    bus_rst,
    input  logic    pme_en,
    input  bus_wr_t wr,
    output cfg_t    cfg,
    output logic    sw_fire
);

    logic keep_wake;
    assign keep_wake = bus_rst & pme_en & ~glb_rst;

    always_ff @(posedge clk) begin
        if (glb_rst || bus_rst) begin
            cfg.rm_rst_en <= 1'b0;
            cfg.cd_en     <= 1'b0;
            cfg.swclr_opt <= 1'b0;
            if (!keep_wake) begin
                cfg.resume_en <= 1'b0;
            end
        end else if (wr.wr) begin
            case (wr.sel)
                SEL_CTRL: begin
                    cfg.resume_en <= wr.data[POS_RESUME];
                    cfg.rm_rst_en <= wr.data[POS_RMRST];
                end
                SEL_INTCFG: cfg.cd_en     <= wr.data[POS_CDEN];
                SEL_GCTL:   cfg.swclr_opt <= wr.data[POS_SWCLR];
                default: ;
            endcase
        end
    end

    // software trigger only counts while the detect enable is on
    assign sw_fire = hits(wr, SEL_CTRL, POS_SWTRIG) & cfg.cd_en;

endmodule

// File: rtl/cdet_event.sv
module cdet_event
    import cdet_pkg::*;
(
    input  logic    clk,
    input  logic    glb_rst,
    input  logic    bus_rst,
    input  logic    pme_en,
    input  bus_wr_t wr,
    input  cfg_t    cfg,
    input  cd_evt_t evt,
    input  logic    sw_fire,
    output logic    flag,
    output logic    wake,
    output logic    rst_pulse
);

    logic sw_pend;
    logic keep_wake;
    logic clr_req;
    logic sw_eff;
    logic flag_set;
    logic wake_set;

    always_comb begin
        keep_wake = bus_rst & pme_en & ~glb_rst;
        clr_req   = hits(wr, SEL_STAT, POS_CDCHG);
        sw_eff    = sw_pend & ~(cfg.swclr_opt & clr_req);
        flag_set  = evt.change | sw_eff;
        wake_set  = cfg.resume_en & evt.change;
    end

    always_ff @(posedge clk) begin
        if (glb_rst || bus_rst) begin
            sw_pend   <= 1'b0;
            rst_pulse <= 1'b0;
            if (!keep_wake) begin
                flag <= 1'b0;
                wake <= 1'b0;
            end
        end else begin
            sw_pend   <= sw_fire;
            rst_pulse <= evt.removal & cfg.rm_rst_en;
            flag      <= flag_set | (flag & ~clr_req);
            wake      <= wake_set | (wake & ~(clr_req & ~flag_set));
        end
    end

endmodule

// File: rtl/cdet_ctl_top.sv
module cdet_ctl_top
    import cdet_pkg::*;
#(
    parameter int NUM_CD = 2
) (
    input  logic              clk,
    input  logic              glb_rst,
    input  logic              bus_rst,
    input  logic              pme_en,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NUM_CD-1:0] cd_n,
    input  logic [1:0]        vsense,
    output logic              csc_irq,
    output logic              wake_n,
    output logic              regs_rst_pulse
);

    bus_wr_t bw;
    cfg_t    cfg;
    cd_evt_t evt;
    logic    sw_fire;
    logic    cd_flag;
    logic    wake_q;
    logic    cd_en_w;
    logic    rm_en_w;

    always_comb begin
        bw.wr   = wr_en;
        bw.sel  = reg_sel_e'(reg_sel);
        bw.data = wdata;
    end

    cdet_sampler #(.NUM_CD(NUM_CD)) u_samp (
        .clk     (clk),
        .any_rst (glb_rst | bus_rst),
        .cd_n    (cd_n),
        .evt     (evt)
    );

    cdet_regs u_regs (
        .clk     (clk),
        .glb_rst (glb_rst),
        .bus_rst (bus_rst),
        .pme_en  (pme_en),
        .wr      (bw),
        .cfg     (cfg),
        .sw_fire (sw_fire)
    );

    cdet_event u_evt (
        .clk       (clk),
        .glb_rst   (glb_rst),
        .bus_rst   (bus_rst),
        .pme_en    (pme_en),
        .wr        (bw),
        .cfg       (cfg),
        .evt       (evt),
        .sw_fire   (sw_fire),
        .flag      (cd_flag),
        .wake      (wake_q),
        .rst_pulse (regs_rst_pulse)
    );

    always_comb begin
        case (bw.sel)
            SEL_CTRL:   rdata = place_bit(POS_VS_HI, vsense[1])
                              | place_bit(POS_VS_LO, vsense[0])
                              | place_bit(POS_RESUME, cfg.resume_en)
                              | place_bit(POS_RMRST, cfg.rm_rst_en);
            SEL_INTCFG: rdata = place_bit(POS_CDEN, cfg.cd_en);
            SEL_STAT:   rdata = place_bit(POS_CDCHG, cd_flag);
            default:    rdata = place_bit(POS_SWCLR, cfg.swclr_opt);
        endcase
    end

    assign csc_irq = cd_flag & cfg.cd_en;
    assign wake_n  = ~wake_q;
    assign cd_en_w = cfg.cd_en;
    assign rm_en_w = cfg.rm_rst_en;

endmodule

// File: rtl/cdet_chk.sv
module cdet_chk (
    input logic       clk,
    input logic       glb_rst,
    input logic       bus_rst,
    input logic       wr_en,
    input logic [1:0] reg_sel,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       csc_irq,
    input logic       wake_n,
    input logic       regs_rst_pulse,
    input logic       flag,
    input logic       cd_en,
    input logic       rm_en
);

    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (glb_rst || bus_rst)
        (reg_sel == 2'd0) |-> (rdata[5] == 1'b0 && rdata[3:2] == 2'b00 && rdata[0] == 1'b0)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (glb_rst || bus_rst)
        (flag && !(wr_en && reg_sel == 2'd2 && wdata[3])) |=> flag); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (glb_rst || bus_rst)
        csc_irq |-> (flag && cd_en)); // R6

    AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (glb_rst || bus_rst)
        !wake_n |-> flag); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (glb_rst || bus_rst)
        regs_rst_pulse |=> !regs_rst_pulse); // R8

    AST_PULSE_NEEDS_CFG: assert property (@(posedge clk) disable iff (glb_rst || bus_rst)
        regs_rst_pulse |-> $past(rm_en)); // R8

endmodule

bind cdet_ctl_top cdet_chk u_chk (
    .clk            (clk),
    .glb_rst        (glb_rst),
    .bus_rst        (bus_rst),
    .wr_en          (wr_en),
    .reg_sel        (reg_sel),
    .wdata          (wdata),
    .rdata          (rdata),
    .csc_irq        (csc_irq),
    .wake_n         (wake_n),
    .regs_rst_pulse (regs_rst_pulse),
    .flag           (cd_flag),
    .cd_en          (cd_en_w),
    .rm_en          (rm_en_w)
);

// File: tb/tb_cdet_ctl_top.sv
module tb_cdet_ctl_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCD        = 2;
    localparam int RAND_STEPS = 4000;

    logic           clk = 1'b0;
    logic           glb_rst, bus_rst, pme_en, wr_en;
    logic [1:0]     reg_sel;
    logic [7:0]     wdata;
    logic [7:0]     rdata;
    logic [NCD-1:0] cd_n;
    logic [1:0]     vsense;
    logic           csc_irq, wake_n, regs_rst_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdet_ctl_top #(.NUM_CD(NCD)) dut (
        .clk(clk), .glb_rst(glb_rst), .bus_rst(bus_rst), .pme_en(pme_en),
        .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
        .cd_n(cd_n), .vsense(vsense), .csc_irq(csc_irq), .wake_n(wake_n),
        .regs_rst_pulse(regs_rst_pulse)
    );

    // reference state, advanced from the requirements
    logic [NCD-1:0] m_cur, m_prev;
    logic m_resume, m_rmrst, m_cden, m_opt, m_flag, m_wake, m_sw, m_pulse;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] s);
        case (s)
            2'd0:    return {vsense[1], vsense[0], 1'b0, m_resume, 2'b00, m_rmrst, 1'b0};
            2'd1:    return {4'b0, m_cden, 3'b0};
            2'd2:    return {4'b0, m_flag, 3'b0};
            default: return {5'b0, m_opt, 2'b0};
        endcase
    endfunction

    function automatic string rd_tag(input logic [1:0] s);
        case (s)
            2'd0:    return "R2";
            2'd2:    return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic model_edge();
        logic keep, chg, rem, clr, sweff, fset;
        if (glb_rst || bus_rst) begin
            keep    = bus_rst && pme_en && !glb_rst;   // R10
            m_cur   = cd_n;
            m_prev  = cd_n;
            m_pulse = 1'b0;
            m_sw    = 1'b0;
            m_rmrst = 1'b0;
            m_cden  = 1'b0;
            m_opt   = 1'b0;
            if (!keep) begin
                m_resume = 1'b0;
                m_flag   = 1'b0;
                m_wake   = 1'b0;
            end
        end else begin
            chg    = (m_cur != m_prev);
            rem    = (m_prev == '0) && (m_cur != '0);
            clr    = wr_en && reg_sel == 2'd2 && wdata[3];
            sweff  = m_sw && !(m_opt && clr);
            fset   = chg || sweff;
            m_wake = (m_resume && chg) || (m_wake && !(clr && !fset));
            m_flag = fset || (m_flag && !clr);
            m_pulse = rem && m_rmrst;
            m_sw   = wr_en && reg_sel == 2'd0 && wdata[5] && m_cden;
            if (wr_en) begin
                case (reg_sel)
                    2'd0: begin m_resume = wdata[4]; m_rmrst = wdata[1]; end
                    2'd1: m_cden = wdata[3];
                    2'd3: m_opt  = wdata[2];
                    default: ;
                endcase
            end
            m_prev = m_cur;
            m_cur  = cd_n;
        end
    endtask

    // inputs are set at the negative edge, outputs are compared at the next negative edge
    task automatic step(input logic w, input logic [1:0] s, input logic [7:0] d);
        wr_en = w; reg_sel = s; wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6", {7'b0, csc_irq}, {7'b0, m_flag && m_cden});
        chk("R7", {7'b0, wake_n}, {7'b0, !m_wake});
        chk("R8", {7'b0, regs_rst_pulse}, {7'b0, m_pulse});
        chk(rd_tag(reg_sel), rdata, exp_rd(reg_sel));
    endtask

    task automatic rd(input logic [1:0] s);
        step(1'b0, s, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        glb_rst = 1'b1; bus_rst = 1'b0; pme_en = 1'b0;
        wr_en = 1'b0; reg_sel = 2'd0; wdata = 8'h00;
        cd_n = '0; vsense = 2'b10;
        @(negedge clk);
        step(1'b0, 2'd0, 8'h00);
        step(1'b0, 2'd0, 8'h00);
        glb_rst = 1'b0;

        // R1: reset state with card present
        chk("R1", rdata, 8'h80);
        chk("R1", {5'b0, wake_n, csc_irq, regs_rst_pulse}, 8'h04);
        rd(2'd2); chk("R1", rdata, 8'h00);

        // R2: reserved bits do not store, live sense bits
        step(1'b1, 2'd0, 8'h2D); vsense = 2'b01; rd(2'd0);
        chk("R2", rdata, 8'h40);
        step(1'b1, 2'd0, 8'h00);

        // R3: software trigger with enable set
        step(1'b1, 2'd1, 8'h08);
        step(1'b1, 2'd0, 8'h20);
        rd(2'd2); chk("R3", rdata, 8'h08);
        chk("R3", {7'b0, wake_n}, 8'h01);           // R7: software trigger does not wake
        step(1'b1, 2'd2, 8'h08); chk("R5", rdata, 8'h00);
        step(1'b1, 2'd1, 8'h00);
        step(1'b1, 2'd0, 8'h20);
        rd(2'd2); rd(2'd2); chk("R3", rdata, 8'h00);

        // R4/R7/R8: removal with resume and reset-on-removal enabled
        step(1'b1, 2'd0, 8'h12);
        cd_n = 2'b01; rd(2'd2);
        chk("R4", rdata, 8'h00);
        rd(2'd2);
        chk("R4", rdata, 8'h08);
        chk("R7", {7'b0, wake_n}, 8'h00);
        chk("R8", {7'b0, regs_rst_pulse}, 8'h01);
        rd(2'd2);
        chk("R8", {7'b0, regs_rst_pulse}, 8'h00);
        chk("R7", {7'b0, wake_n}, 8'h00);
        step(1'b1, 2'd2, 8'h08);
        chk("R7", {7'b0, wake_n}, 8'h01);
        cd_n = 2'b00; rd(2'd2); rd(2'd2);
        chk("R8", {7'b0, regs_rst_pulse}, 8'h00);    // insertion: no pulse
        chk("R4", rdata, 8'h08);
        step(1'b1, 2'd2, 8'h08);

        // R9: cancel option
        step(1'b1, 2'd1, 8'h08);
        step(1'b1, 2'd3, 8'h04);
        step(1'b1, 2'd0, 8'h32);
        step(1'b1, 2'd2, 8'h08);
        rd(2'd2); chk("R9", rdata, 8'h00);
        step(1'b1, 2'd3, 8'h00);
        step(1'b1, 2'd0, 8'h32);
        step(1'b1, 2'd2, 8'h08);
        rd(2'd2); chk("R9", rdata, 8'h08);

        // R10: bus reset with and without power-management mode
        cd_n = 2'b10; rd(2'd2); rd(2'd2);
        pme_en = 1'b1; bus_rst = 1'b1; rd(2'd2); bus_rst = 1'b0;
        chk("R10", rdata, 8'h08);
        chk("R10", {7'b0, wake_n}, 8'h00);
        rd(2'd0); chk("R10", rdata & 8'h12, 8'h10);
        rd(2'd1); chk("R10", rdata, 8'h00);
        pme_en = 1'b0; bus_rst = 1'b1; rd(2'd2); bus_rst = 1'b0;
        chk("R10", rdata, 8'h00);
        chk("R10", {7'b0, wake_n}, 8'h01);

        // random traffic against the reference
        for (int i = 0; i < RAND_STEPS; i++) begin
            int r;
            r = $urandom_range(0, 99);
            glb_rst = (r == 0);
            bus_rst = (r == 1);
            pme_en  = $urandom_range(0, 1);
            if ($urandom_range(0, 7) == 0) cd_n = NCD'($urandom);
            if ($urandom_range(0, 3) == 0) vsense = 2'($urandom);
            step($urandom_range(0, 2) == 0, 2'($urandom), 8'($urandom));
        end
        glb_rst = 1'b0; bus_rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule